// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a register-driven master for the two-wire PHY management interface (MDC clock, MDIO data). Software writes a whole 32-bit management frame word into a frame register. The block then shifts that word onto MDIO, most significant bit first, one bit per MDC period. An optional run of 32 ones goes out ahead of the frame. For a read, the master releases MDIO when the second turnaround bit starts. It then samples the sixteen bits the PHY returns and writes them into the low half of the same frame register.

When the frame ends, the block sets a completion flag in an event register. Software clears the flag by writing 1 to it. The flag also drives a level-sensitive request line.

A speed register sets the MDC divider and holds a preamble-suppress bit. The divider is latched at the start of each transaction, so changing it in the middle of a frame does not disturb that frame. A divider of zero stops MDC, and no transaction can start while the divider is zero.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Register map, selected by `reg_addr`: 0 is the event register, 1 is the frame register and 2 is the speed register. Address 3 reads as zero. After reset every register reads 0, and `mdc`, `mdio_oe` and `mgmt_irq` are low.
- R2: Writing the frame register while idle, with a non-zero divider, starts a transaction. The 32-bit word is sent on `mdio_out` verbatim, bit 31 first, one bit per MDC period. The PHY samples each bit on the rising edge of MDC.
- R3: Unless speed bit 7 is set, 32 one bits are sent before the frame word. When speed bit 7 is 1, the frame word is sent directly with no leading ones.
- R4: The MDC divider is speed bits 6:1. MDC toggles every divider-value module clocks, so one MDC period is 2 × divider clocks.
- R5: `mdio_out` and `mdio_oe` change only in the clock cycle in which MDC falls.
- R6: Frame bits 29:28 equal to 2'b10 select a read. A read drives MDIO only for frame bits 31..17. MDIO is released from frame bit 16 (the second turnaround bit) to the end of the frame. The 16 bits that follow the turnaround are sampled on MDC rising edges, MSB first, and replace frame bits 15:0. Any other opcode drives all 32 bits and leaves the frame register unchanged.
- R7: At the end of a transaction, event bit 23 sets and `mgmt_irq` follows that bit. Writing the event register with bit 23 = 1 clears the flag. Writing it with bit 23 = 0 leaves the flag set.
- R8: A frame-register write while a transaction is in progress is ignored. It does not change the bits sent or the register contents.
- R9: With divider 0, MDC stays low and a frame-register write starts no transaction and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO data driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO data from the pad |
| mgmt_irq | output | 1 | Level-sensitive completion request |

## Verification
The bench runs a grid of transactions: dividers 1, 2 and 3, preamble on and off, and read and write opcodes, each with a different PHY address, register address and data.

For every transaction it checks four things:
- The exact driven bit stream and its length. This separates preamble handling, bit order and the drive window of a read from that of a write.
- The MDC period. This confirms that the divider scales correctly.
- The returned register value. This distinguishes read-back capture from an untouched write.
- The flag: it is set, survives a write of zero, and clears on a write of one.

Separate runs cover a frame write injected mid-transaction and a start attempted with the divider at zero.

// File: rtl/mdio_mgmt_pkg.sv
// Package: shared constants and types for the management frame master.
// Assumes a 32-bit register interface with word addressing on two bits.
package mdio_mgmt_pkg;
    localparam int FRAME_W     = 32;
    localparam int DIV_W       = 6;
    localparam int PRE_W       = 32;
    localparam int DATA_W      = 16;
    localparam int TA2_IDX     = 16;
    localparam int DONE_BIT    = 23;
    localparam int PRE_OFF_BIT = 7;
    localparam int OP_HI       = 29;
    localparam int OP_LO       = 28;
    localparam logic [1:0] OP_READ     = 2'b10;
    localparam logic [1:0] ADDR_EVENT  = 2'd0;
    localparam logic [1:0] ADDR_FRAME  = 2'd1;
    localparam logic [1:0] ADDR_SPEED  = 2'd2;

    typedef enum logic [1:0] {SH_IDLE, SH_ARM, SH_RUN} sh_state_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: mdio_mdc_gen
// Divides the module clock into MDC. MDC toggles every `div` clocks. It also
// produces one-cycle strobes in the cycle at whose end MDC rises or falls.
// Assumes `div` == 0 means MDC is stopped and held low.
module mdio_mdc_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    // Purpose: flag the last clock of each MDC half period.
    always_comb begin
        wrap      = (div != '0) && (cnt >= div - 1'b1);
        rise_tick = wrap && !mdc;
        fall_tick = wrap && mdc;
    end

    // Purpose: count clocks in the half period and toggle MDC on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (div == '0) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Half-period counter stays inside the divider window once the divider is settled.
    assert_cnt_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div != '0 && $stable(div)) |-> (cnt < div));
endmodule

// File: rtl/mdio_frame_shifter.sv
// Module: mdio_frame_shifter
// Sends an optional preamble of ones and then one frame word, MSB first.
// Each bit is launched when MDC falls. For reads it releases the line from
// the second turnaround bit onward and gathers the returned data on MDC
// rising edges. Assumes `start` comes only while idle.
module mdio_frame_shifter
    import mdio_mgmt_pkg::*;
#(
    parameter int FW  = FRAME_W,
    parameter int PW  = PRE_W,
    parameter int DW  = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [FW-1:0] word,
    input  logic          pre_off,
    input  logic          rise_tick,
    input  logic          fall_tick,
    input  logic          mdio_in,
    output logic          mdio_out,
    output logic          mdio_oe,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data
);
    localparam int TOT     = PW + FW;
    localparam int POS_W   = $clog2(TOT + 1);
    localparam int FIDX_W  = $clog2(FW);
    localparam int REL_POS = TOT - 1 - TA2_IDX;
    localparam int CAP_POS = TOT - DW;

    sh_state_t      state;
    logic [POS_W-1:0] pos;
    logic [FW-1:0]  word_q;
    logic           is_rd;
    logic [DW-1:0]  cap;
    logic [POS_W-1:0] pos_nx;

    // Purpose: value of the bit at slot p of the serial stream.
    function automatic logic bit_at(input logic [POS_W-1:0] p, input logic [FW-1:0] w);
        if (int'(p) < PW) return 1'b1;
        return w[FIDX_W'(TOT - 1 - int'(p))];
    endfunction

    // Purpose: whether the master drives slot p.
    function automatic logic drive_at(input logic [POS_W-1:0] p, input logic rd);
        return !(rd && int'(p) >= REL_POS);
    endfunction

    assign pos_nx  = pos + 1'b1;
    assign busy    = (state != SH_IDLE) || done;
    assign rd_data = cap;

    // Purpose: sequence preamble, frame bits, turnaround release and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SH_IDLE;
            pos      <= '0;
            word_q   <= '0;
            is_rd    <= 1'b0;
            cap      <= '0;
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SH_IDLE: begin
                    if (start) begin
                        word_q <= word;
                        is_rd  <= (word[OP_HI:OP_LO] == OP_READ);
                        pos    <= pre_off ? POS_W'(PW) : '0;
                        cap    <= '0;
                        state  <= SH_ARM;
                    end
                end
                SH_ARM: begin
                    if (fall_tick) begin
                        mdio_out <= bit_at(pos, word_q);
                        mdio_oe  <= drive_at(pos, is_rd);
                        state    <= SH_RUN;
                    end
                end
                SH_RUN: begin
                    if (fall_tick) begin
                        if (int'(pos) == TOT - 1) begin
                            state    <= SH_IDLE;
                            mdio_out <= 1'b1;
                            mdio_oe  <= 1'b0;
                            done     <= 1'b1;
                        end else begin
                            pos      <= pos_nx;
                            mdio_out <= bit_at(pos_nx, word_q);
                            mdio_oe  <= drive_at(pos_nx, is_rd);
                        end
                    end else if (rise_tick && is_rd && int'(pos) >= CAP_POS) begin
                        cap <= {cap[DW-2:0], mdio_in};
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    // A new transaction is only requested while the sequencer is idle.
    assert_start_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == SH_IDLE));
    // The line is released in the cycle that reports completion.
    assert_released_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_regs.sv
// Module: mdio_mgmt_regs
// Holds the event, frame and speed registers. It decides when a frame write
// starts a transaction and writes read data back into the frame register.
// Assumes `done` is a one-cycle pulse and `busy` covers that pulse.
module mdio_mgmt_regs
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             busy,
    input  logic             done,
    input  logic [DATA_W-1:0] rd_data,
    output logic             start,
    output logic [DIV_W-1:0] spd_div,
    output logic             pre_off,
    output logic             flag
);
    logic [31:0] frame_q;
    logic        wr_frame;

    assign wr_frame = wr && (addr == ADDR_FRAME);
    assign start    = wr_frame && !busy && (spd_div != '0);

    // Purpose: frame register; writes are taken only while idle, read data lands on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (wr_frame && !busy) begin
            frame_q <= wdata;
        end else if (done && frame_q[OP_HI:OP_LO] == OP_READ) begin
            frame_q[DATA_W-1:0] <= rd_data;
        end
    end

    // Purpose: speed register with divider and preamble-suppress bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spd_div <= '0;
            pre_off <= 1'b0;
        end else if (wr && addr == ADDR_SPEED) begin
            spd_div <= wdata[DIV_W:1];
            pre_off <= wdata[PRE_OFF_BIT];
        end
    end

    // Purpose: completion flag, set by done, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (done) begin
            flag <= 1'b1;
        end else if (wr && addr == ADDR_EVENT && wdata[DONE_BIT]) begin
            flag <= 1'b0;
        end
    end

    // Purpose: read-back multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_EVENT: rdata[DONE_BIT] = flag;
            ADDR_FRAME: rdata = frame_q;
            ADDR_SPEED: begin
                rdata[DIV_W:1]     = spd_div;
                rdata[PRE_OFF_BIT] = pre_off;
            end
            default: rdata = '0;
        endcase
    end

    // Completion always leaves the flag set in the next cycle.
    assert_flag_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag);
    // A frame write during a transaction leaves the register untouched.
    assert_frame_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_frame && busy && !done) |=> $stable(frame_q));
endmodule

// File: rtl/mdio_mgmt_master.sv
// Module: mdio_mgmt_master (top)
// Management frame master: registers, MDC divider and frame shifter. The
// divider is latched when a transaction starts so speed writes cannot upset
// a frame in flight. Assumes an external tristate pad built from mdio_out/mdio_oe.
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in,
    output logic        mgmt_irq
);
    logic             start, busy, done, pre_off, flag;
    logic             rise_tick, fall_tick;
    logic [DIV_W-1:0] spd_div, div_run, div_use;
    logic [DATA_W-1:0] rd_data;

    // Purpose: hold the divider used by the running transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)     div_run <= '0;
        else if (start) div_run <= spd_div;
    end

    assign div_use  = busy ? div_run : spd_div;
    assign mgmt_irq = flag;

    mdio_mgmt_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .busy    (busy),
        .done    (done),
        .rd_data (rd_data),
        .start   (start),
        .spd_div (spd_div),
        .pre_off (pre_off),
        .flag    (flag)
    );

    mdio_mdc_gen #(.DIV_W(DIV_W)) i_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (div_use),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_shifter i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .word      (reg_wdata),
        .pre_off   (pre_off),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data)
    );

    // Line data and enable move only together with a falling MDC.
    assert_mdio_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(mdio_out) || $changed(mdio_oe)) |-> $fell(mdc));
    // With a zero divider and nothing running, MDC is held low.
    assert_mdc_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && spd_div == '0) |=> !mdc);
    // The line is never driven while idle.
    assert_idle_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
endmodule

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe, mgmt_irq;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int fails  = 0;

    // PHY-side observation state
    logic [63:0] stream;
    int          ocnt, dcnt, rises, cyc, lastc, per;
    logic        txn_rd;
    logic [15:0] phy_data;

    always #2.5 clk = ~clk;

    mdio_mgmt_master i_mdio_mgmt_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in), .mgmt_irq(mgmt_irq)
    );

    initial begin
        stream = 0; ocnt = 0; dcnt = 0; rises = 0; cyc = 0; lastc = 0; per = 0;
        txn_rd = 1'b0; phy_data = 16'h0;
    end

    always @(posedge clk) cyc++;

    // PHY receiver: sample driven bits and MDC period on rising MDC
    always @(posedge mdc) begin
        rises++;
        per = cyc - lastc;
        lastc = cyc;
        if (mdio_oe) begin
            stream = {stream[62:0], mdio_out};
            ocnt++;
        end
    end

    // PHY responder: turnaround zero then 16 data bits, launched after falling MDC
    always @(negedge mdc) begin
        #1;
        if (txn_rd && ocnt > 0 && !mdio_oe && dcnt < 17) begin
            mdio_in = (dcnt == 0) ? 1'b0 : phy_data[16 - dcnt];
            dcnt++;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_flag(output bit ok);
        logic [31:0] v;
        ok = 0;
        for (int i = 0; i < 5000; i++) begin
            bus_read(2'd0, v);
            if (v[23]) begin ok = 1; break; end
        end
    endtask

    task automatic run_txn(input int div, input bit pre_off, input bit rd,
                           input logic [31:0] word, input bit inject);
        logic [63:0] full, exp;
        logic [31:0] v;
        bit ok;
        int nexp;
        bus_write(2'd2, {24'd0, pre_off, 6'(div), 1'b0});
        stream = 0; ocnt = 0; dcnt = 0; txn_rd = rd;
        bus_write(2'd1, word);
        if (inject) begin
            repeat (20) @(negedge clk);
            bus_write(2'd1, 32'h5A5A_A5A5);
        end
        wait_flag(ok);
        check("R7 done flag set", 64'(ok), 64'd1);
        check("R7 irq follows flag", 64'(mgmt_irq), 64'd1);
        full = pre_off ? {32'h0, word} : {32'hFFFF_FFFF, word};
        exp  = rd ? (full >> 17) : full;
        nexp = (pre_off ? 0 : 32) + (rd ? 15 : 32);
        check(rd ? "R6 driven bit count" : "R3 driven bit count", 64'(ocnt), 64'(nexp));
        check(inject ? "R8 stream unchanged" : "R2 driven stream", stream, exp);
        check("R4 mdc period", 64'(per), 64'(2 * div));
        bus_read(2'd1, v);
        check(rd ? "R6 read data returned" : (inject ? "R8 frame kept" : "R6 write frame kept"),
              64'(v), 64'(rd ? {word[31:16], phy_data} : word));
        bus_write(2'd0, 32'h0);
        bus_read(2'd0, v);
        check("R7 write zero keeps flag", 64'(v[23]), 64'd1);
        bus_write(2'd0, 32'h0080_0000);
        bus_read(2'd0, v);
        check("R7 write one clears flag", 64'(v[23]), 64'd0);
        check("R7 irq clears", 64'(mgmt_irq), 64'd0);
        txn_rd = 1'b0;
        mdio_in = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int idx;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state and map
        bus_read(2'd0, v); check("R1 event reset", 64'(v), 64'd0);
        bus_read(2'd1, v); check("R1 frame reset", 64'(v), 64'd0);
        bus_read(2'd2, v); check("R1 speed reset", 64'(v), 64'd0);
        bus_read(2'd3, v); check("R1 unused address", 64'(v), 64'd0);
        check("R1 mdc low", 64'(mdc), 64'd0);
        check("R1 oe low", 64'(mdio_oe), 64'd0);
        check("R1 irq low", 64'(mgmt_irq), 64'd0);
        bus_write(2'd2, 32'h0000_00FF);
        bus_read(2'd2, v); check("R1 speed readback", 64'(v), 64'h0000_00FE);

        // R9 divider zero: no clock, no transaction
        bus_write(2'd2, 32'h0);
        rises = 0; ocnt = 0;
        bus_write(2'd1, 32'h5002_0000);
        repeat (200) @(negedge clk);
        check("R9 mdc stays low", 64'(rises), 64'd0);
        check("R9 nothing driven", 64'(ocnt), 64'd0);
        bus_read(2'd0, v); check("R9 no flag", 64'(v[23]), 64'd0);

        // Sweep: divider, preamble, opcode
        idx = 0;
        for (int d = 1; d <= 3; d++) begin
            for (int p = 0; p < 2; p++) begin
                for (int r = 0; r < 2; r++) begin
                    logic [31:0] w;
                    logic [4:0]  pa, ra;
                    pa = 5'(3 * idx + 1);
                    ra = 5'(7 * idx + 2);
                    phy_data = 16'(16'hA5C3 ^ (idx * 16'h1357));
                    if (r == 1) w = {2'b01, 2'b10, pa, ra, 2'b10, 16'h0000};
                    else        w = {2'b01, 2'b01, pa, ra, 2'b10, 16'(16'h3C96 + idx * 16'h0F1)};
                    run_txn(d, p[0], r[0], w, 1'b0);
                    idx++;
                end
            end
        end

        // R8 ignored write mid-transaction (write op)
        run_txn(2, 1'b0, 1'b0, {2'b01, 2'b01, 5'd9, 5'd17, 2'b10, 16'hBEEF}, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule